// File: doc/BRIEF.md
# Random Bit-Duration Spreader

This block drives the spreading input of a serial bus channel's bit-rate oscillator. Varying the length of each data bit lowers radiated emissions. The block runs on the bit-rate clock, and each data bit lasts three cycles of that clock. On every bit boundary it draws a fresh pseudo-random value and scales it to a chosen deviation. It then registers the result as a 6-bit code for a modulation DAC. The 64 codes stand for bit periods that are equally spaced in time between the shortest and the longest period.

Software selects one of four maximal-length shift-register sources and one of four deviation spans. Every span is centred on mid-scale. While spreading is off, the code rests at mid-scale, so the average period matches the unspread rate. Each bus channel uses its own instance, and no state is shared between instances.

Top module: `bitspread_top`

## Requirements
- R1: After reset release the phase counter starts at zero. `bit_stb_o` is high for one cycle out of every three. It is first high after the second rising edge that follows release.
- R2: `code_o` is 6 bits wide and reads 32 (mid-scale) while reset is asserted and until the first strobe edge.
- R3: `code_o` changes only on a rising edge at which `bit_stb_o` is high. It is constant for the whole of each bit.
- R4: If `spread_en_i` is low at a strobe edge, `code_o` becomes 32 after that edge.
- R5: `seq_sel_i` values 0, 1, 2 and 3 pick shift registers of length 7, 9, 11 and 15. Their feedback taps are bits {6,5}, {8,4}, {10,8} and {14,13}. Each register shifts left, and the XOR of its two tap bits enters at bit 0. All four registers are reset to all ones. Each one advances exactly once on every strobe edge, whatever the enable and select inputs are. The raw value is the low 6 bits of the selected register after that advance.
- R6: While spreading is on, the registered code is 32 + floor((raw − 32) / 2^d), where d is `dev_sel_i`. This gives code spans 0..63, 16..47, 24..39 and 28..35 for d = 0, 1, 2 and 3.
- R7: The enable and both select inputs are sampled only at strobe edges. A change between two strobes has no effect on `code_o` until the next strobe edge.
- R8: With full deviation, 60 consecutive bits show at least 16 distinct codes.
- R9: No shift register ever holds the all-zero state, so the sequence never locks up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock, three cycles per data bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spread_en_i | input | 1 | Spreading on when high |
| dev_sel_i | input | 2 | Deviation span select (full, 1/2, 1/4, 1/8) |
| seq_sel_i | input | 2 | Pseudo-random source select |
| code_o | output | 6 | Period code for the modulation DAC |
| bit_stb_o | output | 1 | Marks the last cycle of each data bit |

## Verification
The bench attacks the timing of the code register. It drops the enable, and changes the source select, just after a strobe. A design that samples its inputs every cycle would change the code in the middle of a bit, or would return to mid-scale too early. The bench also checks the extremes of each deviation span against fixed bounds. An arithmetic shift that is off by one would escape the span, and a logical shift would pull the spread off centre. Finally, the bench compares every cycle against a model that advances each register by its tap mask. A wrong tap, a wrong seed or a register that stalls while spreading is off would drift from the model within a few bits.

// File: rtl/bitspread_pkg.sv
`timescale 1ns/1ps
package bitspread_pkg;
  localparam int CODE_W      = 6;
  localparam int CLK_PER_BIT = 3;
  localparam int N_SEQ       = 4;
  localparam int MID         = 2 ** (CODE_W - 1);

  // Register length for each source select value.
  function automatic int seq_len(input int idx);
    case (idx)
      0:       return 7;
      1:       return 9;
      2:       return 11;
      default: return 15;
    endcase
  endfunction

  // Second feedback tap, counted from 1 (the first tap is always the MSB).
  function automatic int seq_tap(input int idx);
    case (idx)
      0:       return 6;
      1:       return 5;
      2:       return 9;
      default: return 14;
    endcase
  endfunction

  // Scale a raw value toward mid-scale by 2**dev, keeping the centre.
  function automatic logic [CODE_W-1:0] dev_scale(input logic [CODE_W-1:0] raw,
                                                  input logic [1:0] dev);
    logic signed [CODE_W:0] off;
    off = $signed({1'b0, raw}) - $signed((CODE_W+1)'(MID));
    off = off >>> dev;
    return CODE_W'(off + $signed((CODE_W+1)'(MID)));
  endfunction

  function automatic logic [CODE_W-1:0] span_lo(input logic [1:0] dev);
    return CODE_W'(MID - (MID >> dev));
  endfunction

  function automatic logic [CODE_W-1:0] span_hi(input logic [1:0] dev);
    return CODE_W'(MID + ((MID - 1) >> dev));
  endfunction
endpackage

// File: rtl/bitspread_phase.sv
`timescale 1ns/1ps
module bitspread_phase #(
  parameter int PERIOD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stb_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign stb_o = (cnt_q == LAST);

  // R1: the strobe never lasts two cycles
  a_r1_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
  // R1: nor does it return after only two cycles
  a_r1_stb_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> ##1 !stb_o);
endmodule

// File: rtl/bitspread_lfsr.sv
`timescale 1ns/1ps
module bitspread_lfsr #(
  parameter int W     = 7,
  parameter int TAP   = 6,
  parameter int OUT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [OUT_W-1:0] raw_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_nx;

  assign state_nx = {state_q[W-2:0], state_q[W-1] ^ state_q[TAP-1]};
  assign raw_o    = state_nx[OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '1;
    else if (adv_i) state_q <= state_nx;
  end

  // R9: the all-zero lock-up state is never entered
  a_r9_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/bitspread_map.sv
`timescale 1ns/1ps
module bitspread_map
  import bitspread_pkg::*;
(
  input  logic              en_i,
  input  logic [1:0]        dev_i,
  input  logic [CODE_W-1:0] raw_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    if (en_i) code_o = dev_scale(raw_i, dev_i);
    else      code_o = CODE_W'(MID);
  end
endmodule

// File: rtl/bitspread_top.sv
`timescale 1ns/1ps
module bitspread_top
  import bitspread_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spread_en_i,
  input  logic [1:0]        dev_sel_i,
  input  logic [1:0]        seq_sel_i,
  output logic [CODE_W-1:0] code_o,
  output logic              bit_stb_o
);
  logic              bit_edge;
  logic [CODE_W-1:0] raw_all [N_SEQ];
  logic [CODE_W-1:0] raw_pick;
  logic [CODE_W-1:0] code_nx;
  logic [CODE_W-1:0] code_q;

  bitspread_phase #(.PERIOD(CLK_PER_BIT)) phase_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_o  (bit_edge)
  );

  for (genvar g = 0; g < N_SEQ; g++) begin : g_src
    bitspread_lfsr #(
      .W     (seq_len(g)),
      .TAP   (seq_tap(g)),
      .OUT_W (CODE_W)
    ) src_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (bit_edge),
      .raw_o  (raw_all[g])
    );
  end

  assign raw_pick = raw_all[seq_sel_i];

  bitspread_map map_i (
    .en_i   (spread_en_i),
    .dev_i  (dev_sel_i),
    .raw_i  (raw_pick),
    .code_o (code_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       code_q <= CODE_W'(MID);
    else if (bit_edge) code_q <= code_nx;
  end

  assign code_o    = code_q;
  assign bit_stb_o = bit_edge;

  // R3: the code holds across every non-boundary edge
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_o |=> $stable(code_o));
  // R4: disabled at a boundary means mid-scale afterwards
  a_r4_idle_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_o && !spread_en_i) |=> (code_o == CODE_W'(MID)));
  // R6: spread codes stay inside the span of the sampled deviation
  a_r6_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_o && spread_en_i) |=>
      (code_o >= span_lo($past(dev_sel_i)) && code_o <= span_hi($past(dev_sel_i))));
endmodule

// File: tb/bitspread_top_tb_top.sv
`timescale 1ns/1ps
module bitspread_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] dev = 2'd0;
  logic [1:0] seq = 2'd0;
  wire  [5:0] code;
  wire        stb;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bitspread_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .spread_en_i(en),
    .dev_sel_i(dev), .seq_sel_i(seq), .code_o(code), .bit_stb_o(stb)
  );

  // ---- independent reference (R5, R6 as written) ----
  localparam int LEN [4] = '{7, 9, 11, 15};
  localparam logic [15:0] MASK [4] = '{16'h0060, 16'h0110, 16'h0500, 16'h6000};

  int         mcnt;
  logic [15:0] ms [4];
  logic [5:0] mcode;

  function automatic logic [15:0] m_adv(input logic [15:0] s, input int i);
    logic fb;
    fb = ^(s & MASK[i]);
    return ((s << 1) | {15'd0, fb}) & 16'((1 << LEN[i]) - 1);
  endfunction

  function automatic logic [5:0] m_scale(input logic [5:0] r, input logic [1:0] d);
    int lo;
    lo = 32 - (32 >> d);
    return 6'(lo + (int'(r) >> d));
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [15:0] nx [4];
    if (!rst_n) begin
      mcnt  <= 0;
      for (int i = 0; i < 4; i++) ms[i] <= 16'((1 << LEN[i]) - 1);
      mcode <= 6'd32;
    end else if (mcnt == 2) begin
      for (int i = 0; i < 4; i++) nx[i] = m_adv(ms[i], i);
      for (int i = 0; i < 4; i++) ms[i] <= nx[i];
      mcode <= en ? m_scale(nx[seq][5:0], dev) : 6'd32;
      mcnt  <= 0;
    end else begin
      mcnt <= mcnt + 1;
    end
  end

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle, compared with the reference at the falling edge.
  task automatic cyc(input string req);
    @(negedge clk);
    chk(req, code === mcode, int'(code), int'(mcode));
    chk(req, stb === (mcnt == 2), int'(stb), int'(mcnt == 2));
  endtask

  task automatic to_strobe();
    do @(negedge clk); while (stb !== 1'b1);
  endtask

  // {en, dev, seq, bits}
  localparam int VEC [8][4] = '{
    '{1, 0, 0, 12}, '{1, 1, 1, 12}, '{1, 2, 2, 12}, '{1, 3, 3, 12},
    '{0, 0, 1, 12}, '{1, 0, 3, 12}, '{1, 3, 0, 12}, '{1, 1, 2, 12}
  };

  localparam int LO [4] = '{0, 16, 24, 28};
  localparam int HI [4] = '{63, 47, 39, 35};

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [5:0]  held;
    logic [63:0] seen;
    int          mn, mx, nd;

    // R2: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R2 reset code", code === 6'd32, int'(code), 32);
      chk("R1 reset strobe", stb === 1'b0, int'(stb), 0);
    end
    en = 1'b1; dev = 2'd0; seq = 2'd0;
    rst_n = 1'b1;

    // R1: strobe pattern 0,1,0,0,1 at falling edges after release
    begin
      int exp_p [5] = '{0, 1, 0, 0, 1};
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk("R1 strobe phase", stb === exp_p[k][0], int'(stb), exp_p[k]);
        if (k < 2) chk("R2 code before first strobe", code === 6'd32, int'(code), 32);
      end
    end

    // Table walk (R4, R5, R6)
    for (int v = 0; v < 8; v++) begin
      to_strobe();
      en = VEC[v][0][0]; dev = VEC[v][1][1:0]; seq = VEC[v][2][1:0];
      for (int c = 0; c < VEC[v][3] * 3; c++) cyc("R5 R6 R4 vector");
    end

    // R6: span bounds for every deviation
    for (int d = 0; d < 4; d++) begin
      to_strobe();
      en = 1'b1; dev = 2'(d); seq = 2'd3;
      @(negedge clk);
      mn = 99; mx = -1;
      for (int c = 0; c < 40 * 3; c++) begin
        cyc("R6 span run");
        if (int'(code) < mn) mn = int'(code);
        if (int'(code) > mx) mx = int'(code);
      end
      chk("R6 span low", mn >= LO[d], mn, LO[d]);
      chk("R6 span high", mx <= HI[d], mx, HI[d]);
    end

    // R8: variety at full deviation
    to_strobe();
    en = 1'b1; dev = 2'd0; seq = 2'd2;
    @(negedge clk);
    seen = '0;
    for (int c = 0; c < 60 * 3; c++) begin
      cyc("R8 variety run");
      seen[code] = 1'b1;
    end
    nd = $countones(seen);
    chk("R8 distinct codes", nd >= 16, nd, 16);

    // R3 R4 R7: drop enable just after a strobe; code holds, then mid-scale
    to_strobe();
    en = 1'b1; dev = 2'd0; seq = 2'd0;
    to_strobe();
    @(negedge clk);
    held = code;
    en = 1'b0;
    @(negedge clk);
    chk("R7 enable mid-bit hold", code === held, int'(code), int'(held));
    @(negedge clk);
    chk("R3 hold to boundary", code === held && stb === 1'b1, int'(code), int'(held));
    @(negedge clk);
    chk("R4 mid-scale after disable", code === 6'd32, int'(code), 32);

    // R7: change source and span mid-bit; code holds until the boundary
    en = 1'b1;
    to_strobe();
    @(negedge clk);
    held = code;
    seq = 2'd1; dev = 2'd3;
    @(negedge clk);
    chk("R7 select mid-bit hold", code === held, int'(code), int'(held));
    for (int c = 0; c < 6; c++) cyc("R7 after select change");

    // R5 R9: long run on the shortest register, past its full period
    to_strobe();
    en = 1'b1; dev = 2'd0; seq = 2'd0;
    for (int c = 0; c < 140 * 3; c++) cyc("R5 R9 long run");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule